// File: doc/BRIEF.md
# Strobe/Acknowledge Byte Output Controller

This block lets a host send single bytes to a slow, asynchronous peripheral without having to toggle the strobe line in software. The host writes a byte through a write strobe. The block latches that byte onto the peripheral data lines and marks a request as pending. A small sequencer then runs a four-phase handshake: it raises the strobe and holds it until the peripheral answers with acknowledge. It drops the strobe once acknowledge arrives. It finishes when acknowledge is released.

When the handshake ends, the sequencer clears the pending request itself, which ends the transfer. The host polls for completion through a read strobe. The top bit of the returned word is 1 when the port is ready and 0 while a transfer is under way. Acknowledge passes through a synchronizer before the sequencer sees it.

Top module: `pport_hs_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle. After that edge, `pp_stb` is 0, `pp_data` is 0 and the ready bit (bit `RD_W-1` of `host_rdata` with `host_rd` high) is 1.
- R2: A `host_wr` pulse in the ready state loads `host_din` into `pp_data` at that clock edge. From the same edge on, the ready bit reads 0.
- R3: `pp_stb` rises exactly one clock edge after the edge that accepted the write.
- R4: While `pp_ack` stays low, `pp_stb` stays high for any number of cycles.
- R5: After `pp_ack` rises, `pp_stb` stays high for two more clock edges, because of the two-flop synchronizer. It goes low at the third edge.
- R6: While `pp_ack` remains high after the strobe has dropped, `pp_stb` stays 0 and the ready bit stays 0.
- R7: After `pp_ack` falls, the ready bit stays 0 for two more edges and becomes 1 at the third edge. No new strobe follows.
- R8: A `host_wr` while the ready bit is 0 is ignored. `pp_data` keeps the byte in flight, and no second transfer starts after the current one completes.
- R9: With `host_rd` high, `host_rdata` carries the ready bit in its top bit and zeros in all lower bits. With `host_rd` low, `host_rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_din | input | DATA_W | Host write data |
| host_rd | input | 1 | Host status read strobe |
| host_rdata | output | RD_W | Status word, ready bit in the MSB |
| pp_data | output | DATA_W | Byte presented to the peripheral |
| pp_stb | output | 1 | Strobe to the peripheral, high means the byte is valid |
| pp_ack | input | 1 | Acknowledge from the peripheral, asynchronous |

## Verification
The main handshake is driven with bytes of all zeros, all ones, alternating bits and a mixed value. This shows that every data bit is latched independently and that no bit is stuck. Each transfer holds acknowledge low and high for several cycles and checks the strobe at the exact edge given by the synchronizer depth. A late or early edge would be caught. Separate tests issue a write in mid-handshake, read with the read strobe low, and reset during an active strobe. These separate blocking of a second request and status gating from the normal path.

// File: rtl/pport_pkg.sv
package pport_pkg;
   typedef enum logic [1:0] {
      HS_IDLE    = 2'd0,
      HS_STROBE  = 2'd1,
      HS_RELEASE = 2'd2
   } hs_state_t;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain[0] <= 1'b0;
      else     chain[0] <= din;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) chain[i] <= 1'b0;
         else     chain[i] <= chain[i-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/pport_datareg.sv
module pport_datareg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [DATA_W-1:0] din,
   input  logic              clr_req,
   output logic [DATA_W-1:0] dout,
   output logic              req
);
   logic accept;
   assign accept = wr & ~req;

   always_ff @(posedge clk) begin
      if (rst) begin
         dout <= '0;
         req  <= 1'b0;
      end else begin
         if (accept) dout <= din;
         if (accept)       req <= 1'b1;
         else if (clr_req) req <= 1'b0;
      end
   end
endmodule

// File: rtl/pport_seq.sv
module pport_seq
   import pport_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic ack_s,
   output logic stb,
   output logic done
);
   hs_state_t state, nxt;

   always_comb begin
      nxt  = state;
      done = 1'b0;
      unique case (state)
         HS_IDLE:    if (req)    nxt = HS_STROBE;
         HS_STROBE:  if (ack_s)  nxt = HS_RELEASE;
         HS_RELEASE: if (!ack_s) begin
                        nxt  = HS_IDLE;
                        done = 1'b1;
                     end
         default:    nxt = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= HS_IDLE;
      else     state <= nxt;
   end

   assign stb = (state == HS_STROBE);
endmodule

// File: rtl/pport_hs_ctrl.sv
module pport_hs_ctrl #(
   parameter int DATA_W      = 8,
   parameter int RD_W        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_din,
   input  logic              host_rd,
   output logic [RD_W-1:0]   host_rdata,
   output logic [DATA_W-1:0] pp_data,
   output logic              pp_stb,
   input  logic              pp_ack
);
   localparam int STAT_BIT = RD_W - 1;

   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end
   if (RD_W < 1) begin : g_bad_rd
      $error("RD_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic ack_s, req, done, ready;

   pport_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(pp_ack), .dout(ack_s)
   );

   pport_datareg #(.DATA_W(DATA_W)) u_dreg (
      .clk(clk), .rst(rst), .wr(host_wr), .din(host_din),
      .clr_req(done), .dout(pp_data), .req(req)
   );

   pport_seq u_seq (
      .clk(clk), .rst(rst), .req(req), .ack_s(ack_s),
      .stb(pp_stb), .done(done)
   );

   assign ready = ~req;

   always_comb begin
      host_rdata = '0;
      if (host_rd) host_rdata[STAT_BIT] = ready;
   end
endmodule

// File: rtl/pport_hs_chk.sv
module pport_hs_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              host_wr,
   input logic              pp_stb,
   input logic [DATA_W-1:0] pp_data,
   input logic              ready,
   input logic              ack_s,
   input logic              done
);
   // R4: strobe only while a request is pending
   p_stb_busy_r4: assert property (@(posedge clk) disable iff (rst)
      pp_stb |-> !ready);

   // R8: data held stable during a transfer
   p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!ready && !$past(ready) && !$past(rst)) |-> $stable(pp_data));

   // R5: strobe drops only after synchronized acknowledge
   p_stb_fall_r5: assert property (@(posedge clk) disable iff (rst)
      ($fell(pp_stb) && !$past(rst)) |-> $past(ack_s));

   // R2: accepted write makes the port busy
   p_wr_busy_r2: assert property (@(posedge clk) disable iff (rst)
      (host_wr && ready) |=> !ready);

   // R7: ready returns only through handshake completion
   p_ready_done_r7: assert property (@(posedge clk) disable iff (rst)
      ($rose(ready) && !$past(rst)) |-> $past(done));
endmodule

bind pport_hs_ctrl pport_hs_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .host_wr(host_wr), .pp_stb(pp_stb),
   .pp_data(pp_data), .ready(ready), .ack_s(ack_s), .done(done)
);

// File: tb/sim_pport_hs_ctrl.sv
`timescale 1ns/1ps
module sim_pport_hs_ctrl;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       host_wr = 1'b0;
   logic [7:0] host_din = '0;
   logic       host_rd = 1'b1;
   logic [7:0] host_rdata;
   logic [7:0] pp_data;
   logic       pp_stb;
   logic       pp_ack = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit done_run = 1'b0;

   always #5 clk = ~clk;

   pport_hs_ctrl u0 (
      .clk(clk), .rst(rst), .host_wr(host_wr), .host_din(host_din),
      .host_rd(host_rd), .host_rdata(host_rdata), .pp_data(pp_data),
      .pp_stb(pp_stb), .pp_ack(pp_ack)
   );

   // data byte, expected status word while busy (stimulus / expected vectors)
   localparam logic [15:0] VEC [4] = '{16'h00_00, 16'hFF_00, 16'hA5_00, 16'h3C_00};

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic nclk(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send(logic [7:0] b, logic [7:0] exp_busy);
      host_wr = 1'b1; host_din = b;
      nclk(1);
      host_wr = 1'b0;
      check("R2 data", pp_data, b);
      check("R2 status", host_rdata, exp_busy);
      check("R3 stb low", pp_stb, 0);
      nclk(1);
      check("R3 stb high", pp_stb, 1);
      nclk(4);
      check("R4 stb hold", pp_stb, 1);
      pp_ack = 1'b1;
      nclk(2);
      check("R5 stb still", pp_stb, 1);
      nclk(1);
      check("R5 stb low", pp_stb, 0);
      nclk(3);
      check("R6 stb", pp_stb, 0);
      check("R6 status", host_rdata, 8'h00);
      pp_ack = 1'b0;
      nclk(2);
      check("R7 busy", host_rdata, 8'h00);
      nclk(1);
      check("R7 ready", host_rdata, 8'h80);
      nclk(3);
      check("R7 no restrobe", pp_stb, 0);
   endtask

   initial begin
      nclk(2);
      rst = 1'b0;
      check("R1 stb", pp_stb, 0);
      check("R1 data", pp_data, 0);
      check("R1 status", host_rdata, 8'h80);

      for (int k = 0; k < 4; k++) send(VEC[k][15:8], VEC[k][7:0]);

      // R9: read gating
      host_rd = 1'b0;
      nclk(1);
      check("R9 rd low", host_rdata, 8'h00);
      host_rd = 1'b1;
      nclk(1);
      check("R9 rd high", host_rdata, 8'h80);

      // R8: write during transfer ignored
      host_wr = 1'b1; host_din = 8'h5A;
      nclk(1);
      host_wr = 1'b0;
      nclk(2);
      host_wr = 1'b1; host_din = 8'h11;
      nclk(1);
      host_wr = 1'b0;
      check("R8 data kept", pp_data, 8'h5A);
      check("R8 stb", pp_stb, 1);
      pp_ack = 1'b1; nclk(4);
      pp_ack = 1'b0; nclk(4);
      check("R8 ready", host_rdata, 8'h80);
      nclk(4);
      check("R8 no second", pp_stb, 0);
      check("R8 data final", pp_data, 8'h5A);

      // R1: reset in mid-strobe
      host_wr = 1'b1; host_din = 8'hC3;
      nclk(1);
      host_wr = 1'b0;
      nclk(2);
      check("R1 pre stb", pp_stb, 1);
      rst = 1'b1;
      nclk(1);
      rst = 1'b0;
      check("R1 rst stb", pp_stb, 0);
      check("R1 rst data", pp_data, 0);
      check("R1 rst status", host_rdata, 8'h80);

      done_run = 1'b1;
   end

   initial begin
      fork
         wait (done_run);
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule